// File: doc/BRIEF.md
# Receive Scatter-Gather Descriptor Writer

This block moves one incoming stream frame into memory by walking a linked chain of buffer descriptors. Each descriptor in memory is nine 32-bit words at consecutive word addresses starting from the descriptor pointer. Offset 0 holds the next-descriptor pointer, offset 1 the buffer word address, offset 2 the control word and offset 3 the status word. Offsets 4 to 8 receive the five sideband words. The engine reads the first four words of a descriptor and writes frame words into that buffer until the buffer is full or the frame ends. It then writes the status back with flag bits ORed in and follows the next pointer.

The stream input follows valid/ready rules. A beat transfers on a rising edge where both `s_valid_i` and `s_ready_o` are high. The sender must hold valid and data stable until that edge. The engine lowers ready whenever it is not collecting data. Ready does not depend on valid, so the sender may look at ready before offering a beat. Every beat but the last carries four bytes. The last beat carries `s_nbytes_i` bytes, from 1 to 4.

The memory side is a single-outstanding word master. The engine asserts `mem_req_o` with its address, direction and write data. The memory returns `mem_ack_i` for one cycle, with read data alongside it on reads. Control is plain level and pulse pins. A pointer load and a tail write arm the engine. It reports the end of each walk with a one-cycle pulse, the number of bytes written and whether the frame end was reached.

Top module: `rxsg_writer`

## Requirements
- R1: After reset `idle_o`=1, `halted_o`=0 and `walk_done_o`=0. `s_ready_o` is high only while `run_i`=1, idle is clear and the current descriptor buffer still has room.
- R2: Once `mem_req_o` is raised, it stays high with `mem_addr_o`, `mem_we_o` and `mem_wdata_o` unchanged until the cycle in which `mem_ack_i` is seen.
- R3: If a fetched status word (offset 3) already has bit 31 set, the engine sets `halted_o` and ends the walk. It writes nothing to that descriptor and leaves `cur_ptr_o` pointing at it.
- R4: A descriptor's capacity is control bits 22:2, counted in whole words. The engine stores min(capacity, beats left in the frame) words at consecutive addresses from the buffer address, and writes no word past that count.
- R5: The first descriptor a frame uses gets status bit 27 set. No later descriptor of that frame gets it.
- R6: Every descriptor the engine uses is written back with status bit 31 set, and all other bits of the fetched status are kept. The descriptor that receives the final beat also gets bit 26 set, and the five latched sideband words are written to offsets 4..8.
- R7: After a descriptor is handled, `cur_ptr_o` takes its next pointer. If that descriptor's address equals the tail pointer, `idle_o` is set and the walk ends, even if frame beats remain. Those beats are not accepted.
- R8: A walk end produces a one-cycle `walk_done_o` pulse. `walk_bytes_o` then shows the bytes stored: 4 per full beat, and `s_nbytes_i` for the last beat. `walk_eof_o` shows 1 only if the final beat was stored.
- R9: A pulse on `app_valid_i` latches five 32-bit sideband words (word k in bits 32k+31:32k). These are the words attached at the next frame end.
- R10: `cur_wr_i` loads the descriptor pointer while no walk is active. `tail_wr_i` loads the tail pointer and clears both idle and halted. A walk starts when valid is seen with run set and idle and halted both clear.
- R11: A descriptor with zero capacity is written back with its flags but takes no data, and the walk continues to the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Engine enable level |
| cur_wr_i | input | 1 | Load the current descriptor pointer |
| cur_ptr_i | input | ADDR_W | New current descriptor pointer |
| tail_wr_i | input | 1 | Load the tail pointer and re-arm |
| tail_ptr_i | input | ADDR_W | New tail pointer |
| idle_o | output | 1 | Tail reached, or not yet armed |
| halted_o | output | 1 | An already-complete descriptor was fetched |
| cur_ptr_o | output | ADDR_W | Current descriptor pointer |
| s_valid_i | input | 1 | Stream beat valid |
| s_ready_o | output | 1 | Stream beat accepted this edge |
| s_data_i | input | 32 | Stream beat data |
| s_last_i | input | 1 | Final beat of the frame |
| s_nbytes_i | input | 3 | Bytes in the final beat, 1..4 |
| app_valid_i | input | 1 | Latch the sideband words |
| app_data_i | input | APP_N*32 | Sideband words |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |
| walk_done_o | output | 1 | One-cycle pulse at walk end |
| walk_eof_o | output | 1 | The walk stored the frame's final beat |
| walk_bytes_o | output | 24 | Bytes stored by the walk |

## Verification
A corrupted word index or capacity shows at the ports within one descriptor. A buffer word lands past the clamp, or the end flag goes to the wrong descriptor, and the checks see it when `walk_done_o` fires. A wrong start-flag or end-flag state shows up in the status words written back during that same walk. A stale pointer or tail comparison shows as a wrong `cur_ptr_o` or `idle_o` right after the pulse, or as a walk that never ends, which the watchdog catches. Stimulus mixes directed chains with random capacities, lengths, tail positions and pre-completed descriptors.

// File: rtl/rxsg_pkg.sv
package rxsg_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_HI   = 22;
  localparam int DONE_BIT = 31;
  localparam int SOF_BIT  = 27;
  localparam int EOF_BIT  = 26;
  localparam int OFS_NEXT = 0;
  localparam int OFS_BUF  = 1;
  localparam int OFS_CTRL = 2;
  localparam int OFS_STAT = 3;
  localparam int OFS_APP  = 4;

  typedef enum logic [3:0] {
    ST_WAIT, ST_RD_NEXT, ST_RD_BUF, ST_RD_CTRL, ST_RD_STAT,
    ST_DATA, ST_WR_DATA, ST_WR_STAT, ST_WR_APP, ST_ADV
  } walk_st_e;
endpackage

// File: rtl/rxsg_app_latch.sv
module rxsg_app_latch #(
  parameter int APP_N = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load_i,
  input  logic [APP_N*rxsg_pkg::WORD_W-1:0]  words_i,
  output logic [APP_N*rxsg_pkg::WORD_W-1:0]  words_o
);
  localparam int W = rxsg_pkg::WORD_W;

  for (genvar k = 0; k < APP_N; k++) begin : g_word
    logic [W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q <= '0;
      else if (load_i) word_q <= words_i[k*W +: W];
    end
    assign words_o[k*W +: W] = word_q;
  end
endmodule

// File: rtl/rxsg_walker.sv
module rxsg_walker #(
  parameter int ADDR_W  = 16,
  parameter int APP_N   = 5,
  parameter int BYTES_W = 24
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               run_i,
  input  logic                               cur_wr_i,
  input  logic [ADDR_W-1:0]                  cur_ptr_i,
  input  logic                               tail_wr_i,
  input  logic [ADDR_W-1:0]                  tail_ptr_i,
  output logic                               idle_o,
  output logic                               halted_o,
  output logic [ADDR_W-1:0]                  cur_ptr_o,
  input  logic                               s_valid_i,
  output logic                               s_ready_o,
  input  logic [rxsg_pkg::WORD_W-1:0]        s_data_i,
  input  logic                               s_last_i,
  input  logic [2:0]                         s_nbytes_i,
  input  logic [APP_N*rxsg_pkg::WORD_W-1:0]  app_words_i,
  output logic                               mem_req_o,
  output logic                               mem_we_o,
  output logic [ADDR_W-1:0]                  mem_addr_o,
  output logic [rxsg_pkg::WORD_W-1:0]        mem_wdata_o,
  input  logic                               mem_ack_i,
  input  logic [rxsg_pkg::WORD_W-1:0]        mem_rdata_i,
  output logic                               walk_done_o,
  output logic                               walk_eof_o,
  output logic [BYTES_W-1:0]                 walk_bytes_o
);
  import rxsg_pkg::*;

  localparam int CAP_W = LEN_HI - 1;
  localparam int IDX_W = (APP_N > 1) ? $clog2(APP_N) : 1;

  walk_st_e            st_q;
  logic [ADDR_W-1:0]   cur_q, tail_q, nxt_q, buf_q;
  logic [CAP_W-1:0]    cap_q, widx_q;
  logic [WORD_W-1:0]   stat_q, beat_q;
  logic [2:0]          nb_q;
  logic                last_q, sof_q, eof_q, idle_q, halted_q;
  logic [IDX_W-1:0]    app_idx_q;
  logic [BYTES_W-1:0]  bytes_q, wbytes_q;
  logic                done_q, weof_q;
  logic [WORD_W-1:0]   flags;

  assign flags = (WORD_W'(1) << DONE_BIT) | (WORD_W'(sof_q) << SOF_BIT) |
                 (WORD_W'(eof_q) << EOF_BIT);

  assign s_ready_o = (st_q == ST_DATA) && run_i && !idle_q;

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_RD_NEXT: mem_addr_o = cur_q + ADDR_W'(OFS_NEXT);
      ST_RD_BUF:  mem_addr_o = cur_q + ADDR_W'(OFS_BUF);
      ST_RD_CTRL: mem_addr_o = cur_q + ADDR_W'(OFS_CTRL);
      ST_RD_STAT: mem_addr_o = cur_q + ADDR_W'(OFS_STAT);
      ST_WR_DATA: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_q + ADDR_W'(widx_q);
        mem_wdata_o = beat_q;
      end
      ST_WR_STAT: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + ADDR_W'(OFS_STAT);
        mem_wdata_o = stat_q | flags;
      end
      ST_WR_APP: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + ADDR_W'(OFS_APP) + ADDR_W'(app_idx_q);
        mem_wdata_o = app_words_i[app_idx_q*WORD_W +: WORD_W];
      end
      default: mem_req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_WAIT;
      cur_q <= '0; tail_q <= '0; nxt_q <= '0; buf_q <= '0;
      cap_q <= '0; widx_q <= '0; stat_q <= '0; beat_q <= '0;
      nb_q <= '0; last_q <= 1'b0; sof_q <= 1'b0; eof_q <= 1'b0;
      idle_q <= 1'b1; halted_q <= 1'b0; app_idx_q <= '0;
      bytes_q <= '0; wbytes_q <= '0; done_q <= 1'b0; weof_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_WAIT: begin
          if (cur_wr_i) cur_q <= cur_ptr_i;
          else if (s_valid_i && run_i && !idle_q && !halted_q) begin
            st_q <= ST_RD_NEXT; bytes_q <= '0; sof_q <= 1'b1; eof_q <= 1'b0;
          end
        end
        ST_RD_NEXT: if (mem_ack_i) begin
          nxt_q <= mem_rdata_i[ADDR_W-1:0]; widx_q <= '0; st_q <= ST_RD_BUF;
        end
        ST_RD_BUF: if (mem_ack_i) begin
          buf_q <= mem_rdata_i[ADDR_W-1:0]; st_q <= ST_RD_CTRL;
        end
        ST_RD_CTRL: if (mem_ack_i) begin
          cap_q <= mem_rdata_i[LEN_HI:2]; st_q <= ST_RD_STAT;
        end
        ST_RD_STAT: if (mem_ack_i) begin
          stat_q <= mem_rdata_i;
          if (mem_rdata_i[DONE_BIT]) begin
            halted_q <= 1'b1; done_q <= 1'b1;
            wbytes_q <= bytes_q; weof_q <= 1'b0; st_q <= ST_WAIT;
          end else if (cap_q == '0) st_q <= ST_WR_STAT;
          else st_q <= ST_DATA;
        end
        ST_DATA: if (s_valid_i && s_ready_o) begin
          beat_q <= s_data_i;
          last_q <= s_last_i;
          nb_q   <= s_last_i ? s_nbytes_i : 3'd4;
          st_q   <= ST_WR_DATA;
        end
        ST_WR_DATA: if (mem_ack_i) begin
          widx_q  <= widx_q + 1'b1;
          bytes_q <= bytes_q + BYTES_W'(nb_q);
          if (last_q) begin eof_q <= 1'b1; st_q <= ST_WR_STAT; end
          else if (widx_q + 1'b1 == cap_q) st_q <= ST_WR_STAT;
          else st_q <= ST_DATA;
        end
        ST_WR_STAT: if (mem_ack_i) begin
          app_idx_q <= '0;
          st_q <= eof_q ? ST_WR_APP : ST_ADV;
        end
        ST_WR_APP: if (mem_ack_i) begin
          if (app_idx_q == IDX_W'(APP_N - 1)) st_q <= ST_ADV;
          else app_idx_q <= app_idx_q + 1'b1;
        end
        ST_ADV: begin
          cur_q <= nxt_q;
          sof_q <= 1'b0;
          if (cur_q == tail_q || eof_q) begin
            if (cur_q == tail_q) idle_q <= 1'b1;
            done_q <= 1'b1; wbytes_q <= bytes_q; weof_q <= eof_q;
            st_q <= ST_WAIT;
          end else st_q <= ST_RD_NEXT;
        end
        default: st_q <= ST_WAIT;
      endcase
      if (tail_wr_i) begin
        tail_q <= tail_ptr_i; idle_q <= 1'b0; halted_q <= 1'b0;
      end
    end
  end

  assign idle_o       = idle_q;
  assign halted_o     = halted_q;
  assign cur_ptr_o    = cur_q;
  assign walk_done_o  = done_q;
  assign walk_eof_o   = weof_q;
  assign walk_bytes_o = wbytes_q;

  // R1
  ready_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (run_i && !idle_o));
  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R3
  halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_o) |-> $past(mem_ack_i && mem_rdata_i[DONE_BIT]));
  // R4
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA || st_q == ST_WR_DATA) |-> (widx_q < cap_q));
  // R7
  tail_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> walk_done_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done_o |=> !walk_done_o);
endmodule

// File: rtl/rxsg_writer.sv
module rxsg_writer #(
  parameter int ADDR_W  = 16,
  parameter int APP_N   = 5,
  parameter int BYTES_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_i,
  input  logic                    cur_wr_i,
  input  logic [ADDR_W-1:0]       cur_ptr_i,
  input  logic                    tail_wr_i,
  input  logic [ADDR_W-1:0]       tail_ptr_i,
  output logic                    idle_o,
  output logic                    halted_o,
  output logic [ADDR_W-1:0]       cur_ptr_o,
  input  logic                    s_valid_i,
  output logic                    s_ready_o,
  input  logic [31:0]             s_data_i,
  input  logic                    s_last_i,
  input  logic [2:0]              s_nbytes_i,
  input  logic                    app_valid_i,
  input  logic [APP_N*32-1:0]     app_data_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [31:0]             mem_wdata_o,
  input  logic                    mem_ack_i,
  input  logic [31:0]             mem_rdata_i,
  output logic                    walk_done_o,
  output logic                    walk_eof_o,
  output logic [BYTES_W-1:0]      walk_bytes_o
);
  logic [APP_N*32-1:0] app_words;

  rxsg_app_latch #(.APP_N(APP_N)) u_app (
    .clk(clk), .rst_n(rst_n), .load_i(app_valid_i),
    .words_i(app_data_i), .words_o(app_words)
  );

  rxsg_walker #(.ADDR_W(ADDR_W), .APP_N(APP_N), .BYTES_W(BYTES_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .run_i(run_i),
    .cur_wr_i(cur_wr_i), .cur_ptr_i(cur_ptr_i),
    .tail_wr_i(tail_wr_i), .tail_ptr_i(tail_ptr_i),
    .idle_o(idle_o), .halted_o(halted_o), .cur_ptr_o(cur_ptr_o),
    .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .s_data_i(s_data_i),
    .s_last_i(s_last_i), .s_nbytes_i(s_nbytes_i), .app_words_i(app_words),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .walk_done_o(walk_done_o), .walk_eof_o(walk_eof_o),
    .walk_bytes_o(walk_bytes_o)
  );
endmodule

// File: tb/rxsg_writer_tb_top.sv
module rxsg_writer_tb_top;
  localparam int AW = 16;
  localparam int NAPP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b1;
  logic cur_wr_i = 1'b0, tail_wr_i = 1'b0;
  logic [AW-1:0] cur_ptr_i = '0, tail_ptr_i = '0;
  logic idle_o, halted_o, s_ready_o;
  logic [AW-1:0] cur_ptr_o;
  logic s_valid_i = 1'b0, s_last_i = 1'b0;
  logic [31:0] s_data_i = '0;
  logic [2:0] s_nbytes_i = 3'd4;
  logic app_valid_i = 1'b0;
  logic [NAPP*32-1:0] app_data_i = '0;
  logic mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic walk_done_o, walk_eof_o;
  logic [23:0] walk_bytes_o;

  always #2 clk = ~clk;

  rxsg_writer dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i),
    .cur_wr_i(cur_wr_i), .cur_ptr_i(cur_ptr_i),
    .tail_wr_i(tail_wr_i), .tail_ptr_i(tail_ptr_i),
    .idle_o(idle_o), .halted_o(halted_o), .cur_ptr_o(cur_ptr_o),
    .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .s_data_i(s_data_i),
    .s_last_i(s_last_i), .s_nbytes_i(s_nbytes_i),
    .app_valid_i(app_valid_i), .app_data_i(app_data_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .walk_done_o(walk_done_o), .walk_eof_o(walk_eof_o),
    .walk_bytes_o(walk_bytes_o)
  );

  logic [31:0] mem [0:1023];
  int checks = 0, fails = 0;
  int cap_w [8];
  bit pre_done [8];
  logic [31:0] st0 [8];
  logic [31:0] app_cur [NAPP];
  bit stop_feed;
  bit finished = 0;

  function automatic logic [AW-1:0] dbase(int i);
    return AW'(16'h100 + 16 * i);
  endfunction
  function automatic logic [AW-1:0] bbase(int i);
    return AW'(16'h200 + 32 * i);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory responder: random latency, one-cycle acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o && ($urandom % 4 != 0)) begin
        if (mem_we_o) mem[mem_addr_o[9:0]] = mem_wdata_o;
        else mem_rdata_i = mem[mem_addr_o[9:0]];
        mem_ack_i = 1'b1;
      end
    end
  end

  task automatic load_app();
    for (int k = 0; k < NAPP; k++) begin
      app_cur[k] = $urandom;
      app_data_i[k*32 +: 32] = app_cur[k];
    end
    @(negedge clk); app_valid_i = 1'b1;
    @(negedge clk); app_valid_i = 1'b0;
  endtask

  task automatic setup_descs();
    for (int i = 0; i < 8; i++) begin
      mem[dbase(i)]     = 32'(dbase((i + 1) % 8));
      mem[dbase(i) + 1] = 32'(bbase(i));
      mem[dbase(i) + 2] = 32'h1000_0000 | 32'(cap_w[i] * 4 + int'($urandom % 4));
      st0[i] = $urandom & 32'h0000_ffff;
      if (pre_done[i]) st0[i] = st0[i] | 32'h8000_0000;
      mem[dbase(i) + 3] = st0[i];
      for (int k = 0; k < NAPP; k++) mem[dbase(i) + 4 + k] = 32'h0;
      for (int k = 0; k < 32; k++) mem[bbase(i) + k] = 32'hEE00_0000 | 32'(i);
    end
  endtask

  task automatic feed(int nbeats, int lastb, int tag);
    for (int b = 0; b < nbeats; b++) begin
      bit sent = 0;
      s_valid_i = 1'b1;
      s_data_i = {16'(tag), 16'(b)};
      s_last_i = (b == nbeats - 1);
      s_nbytes_i = (b == nbeats - 1) ? 3'(lastb) : 3'd4;
      while (!sent && !stop_feed) begin
        if (s_ready_o) begin
          @(posedge clk); @(negedge clk); sent = 1;
        end else @(negedge clk);
      end
      if (stop_feed) break;
    end
    s_valid_i = 1'b0;
    s_last_i = 1'b0;
  endtask

  task automatic run_case(string name, int first, int tail, int len, int tag);
    int nbeats = (len + 3) / 4;
    int lastb = len - 4 * (nbeats - 1);
    int i = first, rem = nbeats, bytes = 0, base = 0;
    bit sof = 1, exp_halt = 0, exp_idle = 0, exp_eof = 0;
    int got_bytes; bit got_eof;
    setup_descs();
    @(negedge clk); cur_wr_i = 1'b1; cur_ptr_i = dbase(first);
    @(negedge clk); cur_wr_i = 1'b0; tail_wr_i = 1'b1; tail_ptr_i = dbase(tail);
    @(negedge clk); tail_wr_i = 1'b0;
    stop_feed = 0;
    fork
      feed(nbeats, lastb, tag);
      begin
        while (!walk_done_o) @(negedge clk);
        got_bytes = int'(walk_bytes_o); got_eof = walk_eof_o;
        stop_feed = 1;
      end
    join
    repeat (4) @(negedge clk);
    // R10 R11 reference walk
    for (int step = 0; step < 9; step++) begin
      int used; bit eofd; int li;
      if (pre_done[i]) begin
        exp_halt = 1;
        // R3 untouched status on the complete descriptor
        chk(mem[dbase(i) + 3] == st0[i], "R3", {name, " status kept"},
            mem[dbase(i) + 3], st0[i]);
        break;
      end
      used = (cap_w[i] < rem) ? cap_w[i] : rem;
      eofd = (used == rem);
      for (int k = 0; k < used; k++)
        chk(mem[bbase(i) + k] == {16'(tag), 16'(base + k)}, "R4", {name, " buffer word"},
            mem[bbase(i) + k], {16'(tag), 16'(base + k)});
      // R4 no word past the clamp
      chk(mem[bbase(i) + used] == (32'hEE00_0000 | 32'(i)), "R4", {name, " past clamp"},
          mem[bbase(i) + used], 32'hEE00_0000 | 32'(i));
      bytes += eofd ? 4 * (used - 1) + lastb : 4 * used;
      // R5 R6 R11 status write-back
      chk(mem[dbase(i) + 3] == (st0[i] | 32'h8000_0000 | (32'(sof) << 27) | (32'(eofd) << 26)),
          "R6", {name, " status"}, mem[dbase(i) + 3],
          st0[i] | 32'h8000_0000 | (32'(sof) << 27) | (32'(eofd) << 26));
      if (eofd)
        for (int k = 0; k < NAPP; k++)
          chk(mem[dbase(i) + 4 + k] == app_cur[k], "R9", {name, " sideband"},
              mem[dbase(i) + 4 + k], app_cur[k]);
      rem -= used; base += used; sof = 0; li = i; i = (i + 1) % 8;
      if (li == tail) begin exp_idle = 1; exp_eof = eofd; break; end
      if (eofd) begin exp_eof = 1; break; end
    end
    chk(got_bytes == bytes, "R8", {name, " bytes"}, got_bytes, bytes);
    chk(got_eof == exp_eof, "R8", {name, " eof"}, got_eof, exp_eof);
    chk(idle_o == exp_idle, "R7", {name, " idle"}, idle_o, exp_idle);
    chk(halted_o == exp_halt, "R3", {name, " halted"}, halted_o, exp_halt);
    chk(cur_ptr_o == dbase(i), "R7", {name, " pointer"}, cur_ptr_o, dbase(i));
    chk(s_ready_o == 1'b0, "R1", {name, " ready after walk"}, s_ready_o, 0);
  endtask

  task automatic default_chain();
    for (int i = 0; i < 8; i++) begin cap_w[i] = 4; pre_done[i] = 0; end
  endtask

  initial begin
    int seen;
    void'($urandom(32'd4242));
    for (int a = 0; a < 1024; a++) mem[a] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(idle_o == 1'b1, "R1", "reset idle", idle_o, 1);
    chk(halted_o == 1'b0, "R1", "reset halted", halted_o, 0);
    chk(walk_done_o == 1'b0, "R1", "reset done", walk_done_o, 0);
    // R1 idle blocks data
    seen = 0;
    s_valid_i = 1'b1; s_last_i = 1'b1; s_nbytes_i = 3'd4;
    repeat (12) begin @(negedge clk); if (s_ready_o || mem_req_o) seen++; end
    s_valid_i = 1'b0;
    chk(seen == 0, "R1", "no accept while idle", seen, 0);

    load_app();
    default_chain();
    run_case("single", 0, 3, 10, 1);
    default_chain(); cap_w[1] = 2; cap_w[2] = 3;
    run_case("multi", 1, 5, 25, 2);
    load_app();
    default_chain(); cap_w[4] = 2;
    run_case("tailstop", 4, 4, 20, 3);
    default_chain(); cap_w[5] = 1; pre_done[6] = 1;
    run_case("halt", 5, 2, 16, 4);
    default_chain(); cap_w[7] = 0; cap_w[0] = 2;
    run_case("zerocap", 7, 2, 5, 5);
    default_chain(); cap_w[2] = 3;
    run_case("exactfit", 2, 6, 12, 6);

    // R1 run low holds ready low
    run_i = 1'b0;
    default_chain(); setup_descs();
    @(negedge clk); cur_wr_i = 1'b1; cur_ptr_i = dbase(0);
    @(negedge clk); cur_wr_i = 1'b0; tail_wr_i = 1'b1; tail_ptr_i = dbase(1);
    @(negedge clk); tail_wr_i = 1'b0;
    seen = 0;
    s_valid_i = 1'b1;
    repeat (20) begin @(negedge clk); if (s_ready_o) seen++; end
    s_valid_i = 1'b0;
    run_i = 1'b1;
    @(negedge clk);
    chk(seen == 0, "R1", "no accept while run low", seen, 0);

    for (int r = 0; r < 12; r++) begin
      for (int i = 0; i < 8; i++) begin
        cap_w[i] = int'($urandom % 7);
        pre_done[i] = ($urandom % 7 == 0);
      end
      if (r % 3 == 0) load_app();
      run_case("random", int'($urandom % 8), int'($urandom % 8),
               1 + int'($urandom % 40), 16 + r);
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule